// File: doc/BRIEF.md
# Store Write Buffer with Selectable Stall and Forwarding Policy

This block sits between an in-order processor and a shared memory bus. The processor hands it stores. The block keeps them in arrival order and writes them onto the bus one at a time, each on a cycle in which the bus grants it. A stall output tells the processor when it must hold its current memory operation.

A compile-time policy parameter decides how the stall behaves and whether loads can be served from the buffer:
- **Policy 0** has one entry. Any load or store waits while that entry is occupied.
- **Policy 1** has `DEPTH` entries. Loads wait until the buffer is empty. Stores wait only when every entry is in use.
- **Policy 2** has one entry. Loads never wait, and a load whose address matches the buffered store is answered with that store's data. A new store waits while the entry is occupied.

Cache storage, bus arbitration and memory are outside the block.

Top module: `store_write_buffer`

## Requirements
- R1: After reset the buffer is empty: `bus_req` is 0, `fwd_hit` is 0, and `cpu_stall` is 0 for any presented operation.
- R2: Policy 0 (`MODE`=0). While the single entry is occupied, any valid operation (`cpu_is_store`=1 for a store, 0 for a load) sees `cpu_stall`=1. When the entry is empty, the operation proceeds, and a store is captured at that clock edge.
- R3: Policy 1 (`MODE`=1). A valid load sees `cpu_stall`=1 while any entry is occupied, including the cycle in which the last entry drains.
- R4: Policy 1. A valid store stalls only when all `DEPTH` entries are occupied and none drains in that cycle. A store offered while full and draining is accepted.
- R5: Policy 2 (`MODE`=2). A valid load never stalls. A valid store sees `cpu_stall`=1 while the single entry is occupied.
- R6: Policy 2. A valid load whose `cpu_addr` equals the buffered store's address drives `fwd_hit`=1 in the same cycle, with `fwd_data` set to that store's data. On an address mismatch, or with an empty buffer, `fwd_hit`=0.
- R7: Under policies 0 and 1, `fwd_hit` is always 0.
- R8: `bus_req` is 1 exactly when the buffer is non-empty. `bus_addr` and `bus_data` show the oldest entry, so stores appear on the bus in acceptance order. While `bus_gnt` is low, that entry stays unchanged.
- R9: An entry leaves the buffer only at the clock edge of a cycle in which `bus_req` and `bus_gnt` are both 1. Exactly one entry leaves per such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor presents a memory operation |
| cpu_is_store | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Operation address |
| cpu_wdata | input | DW | Store data |
| cpu_stall | output | 1 | Processor must hold the operation this cycle |
| fwd_hit | output | 1 | Load address matches the buffered store |
| fwd_data | output | DW | Data forwarded to the load |
| bus_req | output | 1 | Buffer requests the bus for its oldest entry |
| bus_addr | output | AW | Address of the oldest entry |
| bus_data | output | DW | Data of the oldest entry |
| bus_gnt | input | 1 | Bus write of the oldest entry completes this cycle |

## Verification
All three policies are instantiated side by side and compared every cycle against a queue model in the bench.

The directed phases separate the policies:
- Filling the buffer with the grant held low shows that only policy 1 accepts more than one store.
- Offering loads while the buffer is occupied shows that only policy 2 lets them through.
- A store offered while full with the grant raised shows that a drain in the same cycle frees room.
- Matching and non-matching load addresses against a held store confirm that forwarding happens only on an exact match.

A long pseudo-random phase follows. It draws addresses from a small set so that matches and drains in the same cycle as accepts occur often, and it checks bus order against the model.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  // policy encodings
  localparam int unsigned POL_SEQ   = 0;
  localparam int unsigned POL_MULTI = 1;
  localparam int unsigned POL_FWD   = 2;

  // entries actually held for a policy
  function automatic int unsigned eff_depth(input int unsigned mode, input int unsigned depth);
    return (mode == POL_MULTI) ? depth : 1;
  endfunction

  // stall decision for one presented operation
  function automatic logic stall_rule(input int unsigned mode, input logic valid,
                                      input logic is_store, input logic empty,
                                      input logic full, input logic drain);
    logic s;
    s = 1'b0;
    if (valid) begin
      case (mode)
        POL_SEQ:   s = !empty;
        POL_MULTI: s = is_store ? (full && !drain) : !empty;
        default:   s = is_store ? !empty : 1'b0;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/wbuf_store_fifo.sv
module wbuf_store_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full
);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] occ;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty     = (occ == '0);
  assign full      = (occ == CW'(DEPTH));
  assign head_addr = addr_q[rd_ptr];
  assign head_data = data_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      occ <= occ + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= in_addr;
      data_q[wr_ptr] <= in_data;
    end
  end

  // R9: only a present entry can leave
  a_r9_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R4: never more entries than storage
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  // R9: occupancy moves by one per pop
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (occ == $past(occ) - CW'(1)));

endmodule

// File: rtl/wbuf_policy.sv
module wbuf_policy
  import wbuf_pkg::*;
#(
  parameter int unsigned MODE = 1
) (
  input  logic cpu_valid,
  input  logic cpu_is_store,
  input  logic empty,
  input  logic full,
  input  logic drain,
  output logic stall,
  output logic accept_store
);

  assign stall        = stall_rule(MODE, cpu_valid, cpu_is_store, empty, full, drain);
  assign accept_store = cpu_valid && cpu_is_store && !stall;

endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd #(
  parameter int unsigned MODE = 1,
  parameter int unsigned AW   = 16,
  parameter int unsigned DW   = 32
) (
  input  logic          cpu_valid,
  input  logic          cpu_is_store,
  input  logic [AW-1:0] cpu_addr,
  input  logic          empty,
  input  logic [AW-1:0] held_addr,
  input  logic [DW-1:0] held_data,
  output logic          hit,
  output logic [DW-1:0] data
);

  logic addr_match;
  assign addr_match = cpu_valid && !cpu_is_store && !empty && (cpu_addr == held_addr);

  generate
    if (MODE == 2) begin : g_lookup
      assign hit  = addr_match;
      assign data = held_data;
    end else begin : g_nolookup
      assign hit  = 1'b0;
      assign data = addr_match ? held_data : '0;
    end
  endgenerate

endmodule

// File: rtl/store_write_buffer.sv
module store_write_buffer
  import wbuf_pkg::*;
#(
  parameter int unsigned MODE  = 1,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic          cpu_is_store,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_stall,
  output logic          fwd_hit,
  output logic [DW-1:0] fwd_data,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  input  logic          bus_gnt
);

  localparam int unsigned ENTRIES = eff_depth(MODE, DEPTH);

  logic empty, full, drain, push;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic [DW-1:0] fwd_raw;

  assign bus_req = !empty;
  assign drain   = bus_req && bus_gnt;

  wbuf_store_fifo #(.DEPTH(ENTRIES), .AW(AW), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(drain),
    .in_addr(cpu_addr), .in_data(cpu_wdata),
    .head_addr(head_addr), .head_data(head_data),
    .empty(empty), .full(full)
  );

  wbuf_policy #(.MODE(MODE)) u_policy (
    .cpu_valid(cpu_valid), .cpu_is_store(cpu_is_store),
    .empty(empty), .full(full), .drain(drain),
    .stall(cpu_stall), .accept_store(push)
  );

  wbuf_fwd #(.MODE(MODE), .AW(AW), .DW(DW)) u_fwd (
    .cpu_valid(cpu_valid), .cpu_is_store(cpu_is_store), .cpu_addr(cpu_addr),
    .empty(empty), .held_addr(head_addr), .held_data(head_data),
    .hit(fwd_hit), .data(fwd_raw)
  );

  assign fwd_data = fwd_hit ? fwd_raw : '0;
  assign bus_addr = head_addr;
  assign bus_data = head_data;

  // R8: an ungranted head entry is held on the bus
  a_r8_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_data)));
  // R2 / R5: single-entry policies accept a store only into an empty buffer
  a_r2_single_accept_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (push && (MODE != POL_MULTI)) |-> !bus_req);
  // R6 / R7: forwarding only from a held entry, only in policy 2
  a_r6_fwd_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> (bus_req && (MODE == POL_FWD)));
  // R5: loads pass freely in policy 2
  a_r5_load_free: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == POL_FWD && cpu_valid && !cpu_is_store) |-> !cpu_stall);
  // R1: empty out of reset
  a_r1_reset_empty: assert property (@(posedge clk)
    !rst_n |=> !bus_req);

endmodule

// File: tb/store_write_buffer_test.sv
`timescale 1ns/1ps
module store_write_buffer_test;
  localparam int AW = 16, DW = 32, D = 4;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic          valid = 0, is_st = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [2:0]    gnt = '0;
  logic [2:0]    stall_o, hit_o, req_o;
  logic [2:0][DW-1:0] fdata_o, bdata_o;
  logic [2:0][AW-1:0] baddr_o;

  store_write_buffer #(.MODE(1), .DEPTH(D), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(valid), .cpu_is_store(is_st),
    .cpu_addr(addr), .cpu_wdata(wdata), .cpu_stall(stall_o[1]), .fwd_hit(hit_o[1]),
    .fwd_data(fdata_o[1]), .bus_req(req_o[1]), .bus_addr(baddr_o[1]),
    .bus_data(bdata_o[1]), .bus_gnt(gnt[1]));
  store_write_buffer #(.MODE(0), .DEPTH(D), .AW(AW), .DW(DW)) uut_seq (
    .clk(clk), .rst_n(rst_n), .cpu_valid(valid), .cpu_is_store(is_st),
    .cpu_addr(addr), .cpu_wdata(wdata), .cpu_stall(stall_o[0]), .fwd_hit(hit_o[0]),
    .fwd_data(fdata_o[0]), .bus_req(req_o[0]), .bus_addr(baddr_o[0]),
    .bus_data(bdata_o[0]), .bus_gnt(gnt[0]));
  store_write_buffer #(.MODE(2), .DEPTH(D), .AW(AW), .DW(DW)) uut_fwd (
    .clk(clk), .rst_n(rst_n), .cpu_valid(valid), .cpu_is_store(is_st),
    .cpu_addr(addr), .cpu_wdata(wdata), .cpu_stall(stall_o[2]), .fwd_hit(hit_o[2]),
    .fwd_data(fdata_o[2]), .bus_req(req_o[2]), .bus_addr(baddr_o[2]),
    .bus_data(bdata_o[2]), .bus_gnt(gnt[2]));

  // reference model: per-policy ordered list of pending stores
  logic [AW-1:0] qa [3][D];
  logic [DW-1:0] qd [3][D];
  int qn [3];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic bit exp_stall(input int m);
    bit dr;
    dr = (qn[m] > 0) && gnt[m];
    if (!valid) return 0;
    if (m == 0) return qn[m] != 0;
    if (m == 1) return is_st ? (qn[m] == D && !dr) : (qn[m] != 0);
    return is_st ? (qn[m] != 0) : 0;
  endfunction

  function automatic string stall_tag(input int m);
    if (m == 0) return "R2";
    if (m == 1) return is_st ? "R4" : "R3";
    return "R5";
  endfunction

  // one cycle: inputs already driven after a negedge
  task automatic step();
    bit s [3];
    bit h;
    #1;
    for (int m = 0; m < 3; m++) begin
      s[m] = exp_stall(m);
      chk(stall_tag(m), stall_o[m], s[m]);
      h = (m == 2) && valid && !is_st && qn[m] > 0 && qa[m][0] == addr;
      chk(m == 2 ? "R6" : "R7", hit_o[m], h);
      if (h) chk("R6", fdata_o[m], qd[m][0]);
      chk("R9", req_o[m], qn[m] > 0);
      if (qn[m] > 0) begin
        chk("R8", baddr_o[m], qa[m][0]);
        chk("R8", bdata_o[m], qd[m][0]);
      end
    end
    @(posedge clk);
    for (int m = 0; m < 3; m++) begin
      if (qn[m] > 0 && gnt[m]) begin
        for (int k = 0; k < D - 1; k++) begin
          qa[m][k] = qa[m][k+1];
          qd[m][k] = qd[m][k+1];
        end
        qn[m]--;
      end
      if (valid && is_st && !s[m]) begin
        qa[m][qn[m]] = addr;
        qd[m][qn[m]] = wdata;
        qn[m]++;
      end
    end
    @(negedge clk);
  endtask

  task automatic drive(input bit v, input bit st, input int a, input int d, input logic [2:0] g);
    valid = v; is_st = st; addr = AW'(a); wdata = DW'(d); gnt = g;
    step();
  endtask

  initial begin
    for (int m = 0; m < 3; m++) qn[m] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state with a store and a load presented
    valid = 1; is_st = 1; #1;
    for (int m = 0; m < 3; m++) begin
      chk("R1", req_o[m], 0); chk("R1", stall_o[m], 0); chk("R1", hit_o[m], 0);
    end
    is_st = 0; #1;
    for (int m = 0; m < 3; m++) chk("R1", stall_o[m], 0);
    valid = 0;
    // fill with grant low: only policy 1 takes more than one (R2, R4, R5)
    for (int i = 0; i < 5; i++) drive(1, 1, 16 + i, 32'hA000 + i, 3'b000);
    // loads against held stores: match then mismatch (R3, R6, R7)
    drive(1, 0, 16, 0, 3'b000);
    drive(1, 0, 99, 0, 3'b000);
    // R4: store while full and draining
    drive(1, 1, 40, 32'hBEEF, 3'b111);
    // drain everything, loads pending (R3, R8, R9)
    for (int i = 0; i < 6; i++) drive(1, 0, 17, 0, 3'b111);
    drive(0, 0, 0, 0, 3'b000);
    // pseudo-random phase
    for (int i = 0; i < 3000; i++)
      drive($urandom_range(0, 9) < 7, $urandom_range(0, 1), $urandom_range(0, 3),
            $urandom, 3'($urandom));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule